// File: doc/BRIEF.md
# Dual-Limit Window Watchdog Comparator

This block watches a stream of reduced-resolution converter samples (nine-bit signed values, eight magnitude bits plus sign, two's complement). Each sample arrives with the index of the instruction slot that produced it. The block first removes a programmable offset coefficient from the sample, clamping the result to the nine-bit signed range. It then compares the corrected value against the two limits stored for that slot. No linearity correction takes part.

Each limit carries its own direction bit. The bit says whether a sample strictly above the limit or strictly below it counts as a crossing. A crossing sets a sticky status bit for that limit. The interrupt output is raised while any status bit whose enable is set is high. A host reads the status register to learn which limit fired, and that read clears it. The direction bits decide the alarm. Aiming one limit above a high threshold and the other below a low threshold gives an outside-window alarm. Aiming each limit inward gives both status bits for a sample that lies inside the window.

Top module: `wdc_window_watchdog`

## Requirements
- R1: After reset, every limit, direction bit, offset and enable reads back as zero, the status register reads zero and `irq` is low.
- R2: The corrected sample is raw minus offset, clamped to the range -256..255, and only the corrected value is compared.
- R3: Limit A (status bit 0) fires when its direction bit is 1 and the corrected sample is greater than the limit, or when its direction bit is 0 and the sample is less than the limit. Equality never fires.
- R4: Limit B (status bit 1) follows the same rule with its own limit and direction bit.
- R5: A sample is compared only with the two limits stored for the slot index presented with it.
- R6: A status bit, once set, stays set through later non-crossing samples until the status register is read.
- R7: A status read (address 2*SLOTS+2) returns the status bits on `host_rd_data` in the cycle after the request and clears them. A crossing in the same cycle as the read is kept.
- R8: `irq` is high exactly when some status bit is set and its enable bit is set (enable register at address 2*SLOTS+1, bit 0 for A, bit 1 for B). Status bits set even while disabled.
- R9: A cycle with `smp_valid` low changes no status bit, whatever the sample and slot inputs hold.
- R10: With limit A pointed above a low threshold and limit B pointed below a high threshold, a sample inside the window sets both status bits and a sample outside it sets just one.
- R11: Limit A of slot s is at address s and limit B is at SLOTS+s, each as {direction in bit 9, limit in bits 8:0}. The offset is at 2*SLOTS in bits 8:0. These registers read back as written, reading them leaves status intact, and unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_slot | input | SLOT_W (3) | Instruction slot of the sample |
| smp_raw | input | SAMPLE_W (9) | Raw signed sample before offset removal |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_addr | input | ADDR_W (5) | Register write address |
| host_wr_data | input | DATA_W (10) | Register write data |
| host_rd_en | input | 1 | Register read strobe |
| host_rd_addr | input | ADDR_W (5) | Register read address |
| host_rd_data | output | DATA_W (10) | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest case to reach from the ports is a crossing that lands in the very cycle the host reads the status register. The read must return the old value, and the new bit must still survive the clear. The bench drives the sample strobe and the status read on the same clock edge, then reads the status a second time. Saturation is reached by picking offsets that push the difference past either end of the nine-bit range. Each case uses a limit that the wrapped value would cross but the clamped value would not.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  // Two limits per slot: index 0 is limit A, index 1 is limit B.
  localparam int NUM_LIMITS = 2;

  // Direction bit meaning for a limit.
  typedef enum logic {
    DIR_BELOW = 1'b0,
    DIR_ABOVE = 1'b1
  } wdc_dir_e;
endpackage

// File: rtl/wdc_cfg_bank.sv
module wdc_cfg_bank
  import wdc_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 9,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ADDR_W  = $clog2(2 * SLOTS + 3),
  localparam int DATA_W  = SAMPLE_W + 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [DATA_W-1:0]                      wr_data,
  input  logic [ADDR_W-1:0]                      rd_addr,
  input  logic [SLOT_W-1:0]                      sel_slot,
  output logic [NUM_LIMITS-1:0][SAMPLE_W-1:0]    sel_lim,
  output logic [NUM_LIMITS-1:0]                  sel_dir,
  output logic [SAMPLE_W-1:0]                    offset,
  output logic [NUM_LIMITS-1:0]                  irq_en,
  output logic [DATA_W-1:0]                      rd_lim_data
);
  localparam int OFFS_ADDR = 2 * SLOTS;
  localparam int EN_ADDR   = 2 * SLOTS + 1;

  logic [SAMPLE_W-1:0]   lim_q [SLOTS][NUM_LIMITS];
  logic                  dir_q [SLOTS][NUM_LIMITS];
  logic [SAMPLE_W-1:0]   offset_q;
  logic [NUM_LIMITS-1:0] irq_en_q;

  // Limit table: entry (k, s) lives at address k*SLOTS + s.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int k = 0; k < NUM_LIMITS; k++) begin
          lim_q[s][k] <= '0;
          dir_q[s][k] <= 1'b0;
        end
      end
    end else if (wr_en) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int k = 0; k < NUM_LIMITS; k++) begin
          if (wr_addr == ADDR_W'(k * SLOTS + s)) begin
            lim_q[s][k] <= wr_data[SAMPLE_W-1:0];
            dir_q[s][k] <= wr_data[SAMPLE_W];
          end
        end
      end
    end
  end

  // Offset coefficient and per-limit interrupt enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      irq_en_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(OFFS_ADDR)) offset_q <= wr_data[SAMPLE_W-1:0];
      if (wr_addr == ADDR_W'(EN_ADDR))   irq_en_q <= wr_data[NUM_LIMITS-1:0];
    end
  end

  // Limits of the slot that owns the incoming sample.
  always_comb begin
    for (int k = 0; k < NUM_LIMITS; k++) begin
      sel_lim[k] = lim_q[sel_slot][k];
      sel_dir[k] = dir_q[sel_slot][k];
    end
  end

  // Readback of the limit table.
  always_comb begin
    rd_lim_data = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int k = 0; k < NUM_LIMITS; k++) begin
        if (rd_addr == ADDR_W'(k * SLOTS + s))
          rd_lim_data = {dir_q[s][k], lim_q[s][k]};
      end
    end
  end

  assign offset = offset_q;
  assign irq_en = irq_en_q;
endmodule

// File: rtl/wdc_window_cmp.sv
module wdc_window_cmp
  import wdc_pkg::*;
#(
  parameter int SAMPLE_W = 9
) (
  input  logic [SAMPLE_W-1:0]                 raw,
  input  logic [SAMPLE_W-1:0]                 offset,
  input  logic [NUM_LIMITS-1:0][SAMPLE_W-1:0] lim,
  input  logic [NUM_LIMITS-1:0]               dir,
  output logic [SAMPLE_W-1:0]                 corrected,
  output logic [NUM_LIMITS-1:0]               hit
);
  // Signed subtraction clamped to the SAMPLE_W signed range.
  function automatic logic [SAMPLE_W-1:0] sat_sub(
    input logic [SAMPLE_W-1:0] a,
    input logic [SAMPLE_W-1:0] b
  );
    logic [SAMPLE_W:0] d;
    d = {a[SAMPLE_W-1], a} - {b[SAMPLE_W-1], b};
    if (d[SAMPLE_W] == d[SAMPLE_W-1])
      return d[SAMPLE_W-1:0];
    else if (d[SAMPLE_W] == 1'b0)
      return {1'b0, {(SAMPLE_W-1){1'b1}}};
    else
      return {1'b1, {(SAMPLE_W-1){1'b0}}};
  endfunction

  // Strict signed crossing test in the selected direction.
  function automatic logic crosses(
    input logic [SAMPLE_W-1:0] value,
    input logic [SAMPLE_W-1:0] limit,
    input wdc_dir_e            way
  );
    if (way == DIR_ABOVE) return $signed(value) > $signed(limit);
    else                  return $signed(value) < $signed(limit);
  endfunction

  assign corrected = sat_sub(raw, offset);

  for (genvar k = 0; k < NUM_LIMITS; k++) begin : g_lim
    assign hit[k] = crosses(corrected, lim[k], wdc_dir_e'(dir[k]));
  end
endmodule

// File: rtl/wdc_status_ctl.sv
module wdc_status_ctl
  import wdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [NUM_LIMITS-1:0] hit,
  input  logic                  clr,
  input  logic [NUM_LIMITS-1:0] irq_en,
  output logic [NUM_LIMITS-1:0] status,
  output logic                  irq
);
  logic [NUM_LIMITS-1:0] status_q;
  logic [NUM_LIMITS-1:0] set_v;

  assign set_v = hit & {NUM_LIMITS{smp_valid}};

  // A fresh crossing outranks the clear that comes with a status read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (clr ? '0 : status_q) | set_v;
  end

  assign status = status_q;
  assign irq    = |(status_q & irq_en);
endmodule

// File: rtl/wdc_window_watchdog.sv
module wdc_window_watchdog
  import wdc_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 9,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ADDR_W  = $clog2(2 * SLOTS + 3),
  localparam int DATA_W  = SAMPLE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SLOT_W-1:0] smp_slot,
  input  logic [SAMPLE_W-1:0] smp_raw,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_rd_addr,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              irq
);
  localparam int OFFS_ADDR = 2 * SLOTS;
  localparam int EN_ADDR   = 2 * SLOTS + 1;
  localparam int STAT_ADDR = 2 * SLOTS + 2;

  // Named internal events, visible to the bound checker.
  logic [NUM_LIMITS-1:0][SAMPLE_W-1:0] sel_lim;
  logic [NUM_LIMITS-1:0]               sel_dir;
  logic [SAMPLE_W-1:0]                 offset;
  logic [NUM_LIMITS-1:0]               irq_en;
  logic [DATA_W-1:0]                   rd_lim_data;
  logic [SAMPLE_W-1:0]                 corrected;
  logic [NUM_LIMITS-1:0]               cmp_hit;
  logic [NUM_LIMITS-1:0]               status;
  logic                                stat_clr;
  logic [DATA_W-1:0]                   rd_val;
  logic [DATA_W-1:0]                   rd_data_q;

  wdc_cfg_bank #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (host_wr_en),
    .wr_addr     (host_wr_addr),
    .wr_data     (host_wr_data),
    .rd_addr     (host_rd_addr),
    .sel_slot    (smp_slot),
    .sel_lim     (sel_lim),
    .sel_dir     (sel_dir),
    .offset      (offset),
    .irq_en      (irq_en),
    .rd_lim_data (rd_lim_data)
  );

  wdc_window_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .raw       (smp_raw),
    .offset    (offset),
    .lim       (sel_lim),
    .dir       (sel_dir),
    .corrected (corrected),
    .hit       (cmp_hit)
  );

  assign stat_clr = host_rd_en && (host_rd_addr == ADDR_W'(STAT_ADDR));

  wdc_status_ctl u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .hit       (cmp_hit),
    .clr       (stat_clr),
    .irq_en    (irq_en),
    .status    (status),
    .irq       (irq)
  );

  // Host read mux, registered one cycle.
  always_comb begin
    rd_val = '0;
    if (host_rd_addr < ADDR_W'(OFFS_ADDR))       rd_val = rd_lim_data;
    else if (host_rd_addr == ADDR_W'(OFFS_ADDR)) rd_val = DATA_W'(offset);
    else if (host_rd_addr == ADDR_W'(EN_ADDR))   rd_val = DATA_W'(irq_en);
    else if (host_rd_addr == ADDR_W'(STAT_ADDR)) rd_val = DATA_W'(status);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data_q <= '0;
    else if (host_rd_en) rd_data_q <= rd_val;
  end

  assign host_rd_data = rd_data_q;
endmodule

// File: rtl/wdc_window_watchdog_chk.sv
module wdc_window_watchdog_chk #(
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 9,
  localparam int ADDR_W  = $clog2(2 * SLOTS + 3),
  localparam int DATA_W  = SAMPLE_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_wr_addr,
  input logic              host_rd_en,
  input logic [ADDR_W-1:0] host_rd_addr,
  input logic [DATA_W-1:0] host_rd_data,
  input logic              irq,
  input logic [1:0]        cmp_hit,
  input logic [1:0]        status,
  input logic [1:0]        irq_en
);
  localparam int EN_ADDR   = 2 * SLOTS + 1;
  localparam int STAT_ADDR = 2 * SLOTS + 2;

  logic stat_rd;
  assign stat_rd = host_rd_en && (host_rd_addr == ADDR_W'(STAT_ADDR));

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(smp_valid && (|cmp_hit))) |=> (status == 2'b00));

  // R7
  status_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (host_rd_data == DATA_W'($past(status))));

  // R9
  no_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ((status & ~$past(status)) == 2'b00));

  // R3
  hit_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cmp_hit[0]) |=> status[0]);

  // R4
  hit_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cmp_hit[1]) |=> status[1]);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(smp_valid && (|cmp_hit)) ||
                    $past(host_wr_en && (host_wr_addr == ADDR_W'(EN_ADDR)))));
endmodule

bind wdc_window_watchdog wdc_window_watchdog_chk #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_valid    (smp_valid),
  .host_wr_en   (host_wr_en),
  .host_wr_addr (host_wr_addr),
  .host_rd_en   (host_rd_en),
  .host_rd_addr (host_rd_addr),
  .host_rd_data (host_rd_data),
  .irq          (irq),
  .cmp_hit      (cmp_hit),
  .status       (status),
  .irq_en       (irq_en)
);

// File: tb/tb_wdc_window_watchdog.sv
`timescale 1ns/1ps
module tb_wdc_window_watchdog;
  localparam int OFFS = 16;
  localparam int ENA  = 17;
  localparam int STAT = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [2:0] smp_slot = '0;
  logic [8:0] smp_raw = '0;
  logic       host_wr_en = 1'b0;
  logic [4:0] host_wr_addr = '0;
  logic [9:0] host_wr_data = '0;
  logic       host_rd_en = 1'b0;
  logic [4:0] host_rd_addr = '0;
  logic [9:0] host_rd_data;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  int la [8];
  int lb [8];
  int da [8];
  int db [8];
  int cur_off = 0;

  always #2.5 clk = ~clk;

  wdc_window_watchdog dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_slot(smp_slot),
    .smp_raw(smp_raw), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp9(input int v);
    if (v > 255) return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  function automatic int model_status(input int slot, input int raw);
    int c;
    int r;
    c = clamp9(raw - cur_off);
    r = 0;
    if (da[slot] != 0 ? (c > la[slot]) : (c < la[slot])) r += 1;
    if (db[slot] != 0 ? (c > lb[slot]) : (c < lb[slot])) r += 2;
    return r;
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = 5'(addr); host_wr_data = 10'(data);
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output int v);
    @(negedge clk);
    host_rd_en = 1'b1; host_rd_addr = 5'(addr);
    @(negedge clk);
    v = int'(host_rd_data);
    host_rd_en = 1'b0;
  endtask

  task automatic cfg(input int s, input int a, input int ad, input int b, input int bd);
    la[s] = a; da[s] = ad; lb[s] = b; db[s] = bd;
    wr(s, (ad << 9) | (a & 511));
    wr(8 + s, (bd << 9) | (b & 511));
  endtask

  task automatic set_off(input int o);
    cur_off = o;
    wr(OFFS, o & 511);
  endtask

  task automatic send(input int slot, input int raw);
    @(negedge clk);
    smp_valid = 1'b1; smp_slot = 3'(slot); smp_raw = 9'(raw);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear_status();
    int v;
    rd(STAT, v);
  endtask

  // Send one sample, then read and compare status with the model.
  task automatic probe(input string req, input int slot, input int raw);
    int v;
    clear_status();
    send(slot, raw);
    rd(STAT, v);
    chk(req, v, model_status(slot, raw));
  endtask

  task automatic t_reset();
    int v;
    chk("R1 irq", int'(irq), 0);
    rd(STAT, v); chk("R1 status", v, 0);
    rd(0, v);    chk("R1 limA slot0", v, 0);
    rd(15, v);   chk("R1 limB slot7", v, 0);
    rd(OFFS, v); chk("R1 offset", v, 0);
    rd(ENA, v);  chk("R1 enable", v, 0);
  endtask

  task automatic t_readback();
    int v;
    cfg(3, -5, 1, 77, 0);
    rd(3, v);  chk("R11 limA readback", v, (1 << 9) | (-5 & 511));
    rd(11, v); chk("R11 limB readback", v, 77);
    set_off(-3);
    rd(OFFS, v); chk("R11 offset readback", v, -3 & 511);
    set_off(0);
    wr(31, 1023);
    rd(31, v); chk("R11 unmapped", v, 0);
  endtask

  task automatic t_limit_a();
    cfg(0, 10, 1, 0, 0);
    probe("R3 equal above", 0, 10);
    probe("R3 above", 0, 11);
    cfg(0, 10, 0, 0, 0);
    probe("R3 equal below", 0, 10);
    probe("R3 below", 0, 9);
  endtask

  task automatic t_limit_b();
    cfg(1, 0, 1, -20, 0);
    probe("R4 equal below", 1, -20);
    probe("R4 below", 1, -21);
    cfg(1, 0, 1, 40, 1);
    probe("R4 above", 1, 41);
  endtask

  task automatic t_slot();
    cfg(2, 100, 1, -200, 0);
    cfg(4, 0, 1, -200, 0);
    probe("R5 slot2 no hit", 2, 50);
    probe("R5 slot4 hit", 4, 50);
  endtask

  task automatic t_offset();
    cfg(5, 20, 1, -256, 0);
    set_off(30);
    probe("R2 offset equal", 5, 50);
    probe("R2 offset above", 5, 51);
    set_off(100);
    probe("R2 clamp low", 5, -200);   // wraps to 212 if unclamped
    cfg(6, 255, 0, 0, 1);
    set_off(-100);
    probe("R2 clamp high", 6, 200);   // wraps to -212 if unclamped
    set_off(0);
  endtask

  task automatic t_sticky_irq();
    int v;
    cfg(0, 10, 1, 0, 0);
    wr(ENA, 0);
    clear_status();
    send(0, 11);
    chk("R8 irq masked", int'(irq), 0);
    send(0, 5);
    wr(ENA, 1);
    chk("R8 irq enabled", int'(irq), 1);
    rd(ENA, v); chk("R11 enable readback", v, 1);
    chk("R11 no clear on other read", int'(irq), 1);
    rd(STAT, v); chk("R6 sticky bit", v, 1);
    chk("R7 irq after clear", int'(irq), 0);
    rd(STAT, v); chk("R7 cleared", v, 0);
    wr(ENA, 2);
    send(0, 11);
    chk("R8 other enable", int'(irq), 0);
    wr(ENA, 0);
  endtask

  task automatic t_ignore();
    int v;
    cfg(0, 10, 1, 0, 0);
    clear_status();
    @(negedge clk);
    smp_valid = 1'b0; smp_slot = 3'd0; smp_raw = 9'd100;
    @(negedge clk);
    @(negedge clk);
    rd(STAT, v); chk("R9 idle ignored", v, 0);
  endtask

  task automatic t_race();
    int v;
    cfg(0, 10, 1, 0, 0);
    clear_status();
    @(negedge clk);
    smp_valid = 1'b1; smp_slot = 3'd0; smp_raw = 9'd50;
    host_rd_en = 1'b1; host_rd_addr = 5'(STAT);
    @(negedge clk);
    v = int'(host_rd_data);
    smp_valid = 1'b0; host_rd_en = 1'b0;
    chk("R7 read returns old", v, 0);
    rd(STAT, v); chk("R7 same-cycle hit kept", v, 1);
  endtask

  task automatic t_window();
    cfg(7, -50, 1, 50, 0);
    probe("R10 inside", 7, 0);
    probe("R10 above window", 7, 60);
    probe("R10 below window", 7, -60);
    cfg(7, 50, 1, -50, 0);
    probe("R10 outside cfg inside", 7, 0);
    probe("R10 outside cfg high", 7, 60);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin la[i] = 0; lb[i] = 0; da[i] = 0; db[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_limit_a();
    t_limit_b();
    t_slot();
    t_offset();
    t_sticky_irq();
    t_ignore();
    t_race();
    t_window();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule